// File: doc/BRIEF.md
# Two-Target I2C Slave Front End

This block is the bus-facing slave of a part that holds two storage spaces behind one two-wire serial port: a byte-wide memory array with a 15-bit address and a small clock/control register file addressed by one byte. It samples the serial clock and data lines with the system clock and finds start, stop and repeated-start conditions. It decodes the 7-bit slave identifier to choose a target, and it turns bus transactions into single-cycle requests on a synchronous memory port. Acknowledge and read data leave the block as an open-drain pull-down enable.

A write transaction carries the slave byte, a word address sent high byte first, and then one or more data bytes. Consecutive data bytes fill one 128-byte page and wrap inside it. A read either continues from an internal address counter or, when a dummy write that sets the address comes before it, starts from that address. The counter survives between transactions. It is cleared only by reset.

Top module: `twin_i2c_slave`

## Requirements
- R1: After a start, the block acknowledges a slave byte only when its upper seven bits equal 1010111 (memory array, mem_sel=0) or 1101111 (register file, mem_sel=1). Any other identifier gets no acknowledge, and the block ignores the bus until the next start.
- R2: Bit 0 of the slave byte selects the direction: 0 means the master writes (word address bytes follow), 1 means the block returns data bytes.
- R3: After a write slave byte, the block acknowledges two word-address bytes, high byte first. The array address is the low 7 bits of the high byte followed by the 8 bits of the low byte.
- R4: Each data byte of a write is acknowledged and produces exactly one one-cycle write request (mem_req=1, mem_we=1) that carries the selected target, the current address and the byte.
- R5: Within one write transaction the address advances by one after each data byte. Only the low 7 bits take part, so the address wraps inside its 128-byte page and the upper bits stay unchanged.
- R6: After reset the address counter is 0, so a read with no address set beforehand starts at location 0.
- R7: A read returns one byte per master acknowledge and advances the counter after each byte sent. A master no-acknowledge followed by a stop ends the read, and the next read without an address continues at the following location. Both targets share this single counter.
- R8: When a read slave byte follows a repeated start after a dummy write, and its identifier names the other target, it is not acknowledged.
- R9: A read after a dummy write to the same target returns data starting at the address that the dummy write set.
- R10: A stop at any point releases SDA and ends the transaction without a memory write. A later start is served normally.
- R11: For the register target only the low 8 address bits are used. Every request to it carries zero in address bits 14 to 8, and reads wrap within 256 locations.
- R12: The block changes its SDA pull-down only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| mem_req | output | 1 | One-cycle storage access request |
| mem_we | output | 1 | 1 write, 0 read, valid with mem_req |
| mem_sel | output | 1 | Target: 0 memory array, 1 register file |
| mem_addr | output | 15 | Storage address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid one cycle after a read request |

## Verification
The bench uses the default parameters: a 15-bit array address, 7-bit page offsets and an 8-bit register window. With these values a short write that starts near offset 0x7C crosses the page end and shows the wrap. A read of the register space shows the masking of the high address byte. Random page writes of up to 12 bytes to random addresses in both targets, each followed by a random read through a dummy write, cover the wrap and the target choice at many addresses. Directed sequences cover the power-up counter, the shared counter across targets, identifier mismatch and a stop partway through a transaction.

// File: rtl/dts_pkg.sv
package dts_pkg;
  typedef enum logic [2:0] {PH_IDLE, PH_RX, PH_ACK, PH_TX, PH_MACK} phase_e;
  typedef enum logic [1:0] {K_DEV, K_AHI, K_ALO, K_DATA} kind_e;
  localparam logic TGT_REGS = 1'b1;
endpackage

// File: rtl/dts_rst_sync.sv
module dts_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [1:0] stage;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage <= 2'b00;
    else        stage <= {stage[0], 1'b1};
  end

  assign rst_ns = stage[1];
endmodule

// File: rtl/dts_line_sync.sv
module dts_line_sync (
  input  logic clk,
  input  logic rst_ns,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic [1:0] scl_q, sda_q;
  logic       scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      scl_q <= 2'b11;
      sda_q <= 2'b11;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[0], scl_i};
      sda_q <= {sda_q[0], sda_i};
      scl_d <= scl_q[1];
      sda_d <= sda_q[1];
    end
  end

  assign scl_s     = scl_q[1];
  assign sda_s     = sda_q[1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  // data edges are only conditions while the clock stays high
  assign bus_start = scl_s & scl_d & sda_d & ~sda_s;
  assign bus_stop  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/dts_engine.sv
module dts_engine
  import dts_pkg::*;
#(
  parameter int         ADDR_W   = 15,
  parameter int         PAGE_W   = 7,
  parameter int         REG_AW   = 8,
  parameter logic [6:0] ARRAY_ID = 7'b1010111,
  parameter logic [6:0] REGS_ID  = 7'b1101111
) (
  input  logic              clk,
  input  logic              rst_ns,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              bus_start,
  input  logic              bus_stop,
  output logic              sda_oe,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_sel,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata
);
  localparam int                HI_W   = ADDR_W - 8;
  localparam logic [PAGE_W-1:0] PG_ONE = PAGE_W'(1);
  localparam logic [ADDR_W-1:0] AD_ONE = ADDR_W'(1);

  phase_e              phase, phase_n;
  kind_e               kind, kind_n;
  logic [3:0]          cnt, cnt_n;
  logic [7:0]          shreg, sh_n, txreg, tx_n;
  logic                oe_n, tgt, tgt_n, rd_mode, rd_n;
  logic                dw_valid, dw_n, dw_tgt, dwt_n, cap, cap_n;
  logic [ADDR_W-1:0]   addr, addr_n, maddr_n;
  logic [HI_W-1:0]     addr_hi, hi_n;
  logic                req_n, we_n, sel_n;
  logic [7:0]          wd_n;
  logic                hit_a, hit_r, id_t;

  function automatic logic [ADDR_W-1:0] fit(input logic [ADDR_W-1:0] a, input logic t);
    logic [ADDR_W-1:0] m;
    m = a;
    if (t == TGT_REGS) m[ADDR_W-1:REG_AW] = '0;
    return m;
  endfunction

  assign hit_a = (shreg[7:1] == ARRAY_ID);
  assign hit_r = (shreg[7:1] == REGS_ID);
  assign id_t  = hit_r;

  always_comb begin
    phase_n = phase;   kind_n = kind;   cnt_n = cnt;   sh_n = shreg;
    tx_n    = txreg;   oe_n   = sda_oe; addr_n = addr; hi_n = addr_hi;
    tgt_n   = tgt;     rd_n   = rd_mode; dw_n = dw_valid; dwt_n = dw_tgt;
    req_n   = 1'b0;    we_n   = 1'b0;   sel_n = mem_sel;
    maddr_n = mem_addr; wd_n  = mem_wdata;
    cap_n   = mem_req & ~mem_we;
    if (cap) tx_n = mem_rdata;
    if (bus_stop) begin
      phase_n = PH_IDLE; oe_n = 1'b0; dw_n = 1'b0;
    end else if (bus_start) begin
      phase_n = PH_RX; kind_n = K_DEV; cnt_n = 4'd0; oe_n = 1'b0;
    end else begin
      case (phase)
        PH_RX: begin
          if (scl_rise) begin
            sh_n  = {shreg[6:0], sda_s};
            cnt_n = cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            oe_n = 1'b1; phase_n = PH_ACK; rd_n = 1'b0;
            case (kind)
              K_DEV: begin
                if (!(hit_a || hit_r) || (shreg[0] && dw_valid && dw_tgt != id_t)) begin
                  oe_n = 1'b0; phase_n = PH_IDLE;
                end else if (shreg[0]) begin
                  tgt_n = id_t; rd_n = 1'b1; req_n = 1'b1;
                  sel_n = id_t; maddr_n = fit(addr, id_t);
                end else begin
                  tgt_n = id_t; kind_n = K_AHI; dw_n = 1'b0;
                end
              end
              K_AHI: begin
                hi_n = shreg[HI_W-1:0]; kind_n = K_ALO;
              end
              K_ALO: begin
                addr_n = (tgt == TGT_REGS) ? fit(ADDR_W'(shreg), 1'b1) : {addr_hi, shreg};
                kind_n = K_DATA; dw_n = 1'b1; dwt_n = tgt;
              end
              default: begin
                req_n = 1'b1; we_n = 1'b1; sel_n = tgt; maddr_n = addr; wd_n = shreg;
                addr_n = {addr[ADDR_W-1:PAGE_W], addr[PAGE_W-1:0] + PG_ONE};
              end
            endcase
          end
        end
        PH_ACK: begin
          if (scl_fall) begin
            if (rd_mode) begin
              phase_n = PH_TX; oe_n = ~txreg[7]; cnt_n = 4'd1;
            end else begin
              phase_n = PH_RX; oe_n = 1'b0; cnt_n = 4'd0;
            end
          end
        end
        PH_TX: begin
          if (scl_fall) begin
            if (cnt == 4'd8) begin
              oe_n = 1'b0; phase_n = PH_MACK; addr_n = fit(addr + AD_ONE, tgt);
            end else begin
              tx_n = {txreg[6:0], 1'b0}; oe_n = ~txreg[6]; cnt_n = cnt + 4'd1;
            end
          end
        end
        PH_MACK: begin
          if (scl_rise) begin
            if (sda_s) phase_n = PH_IDLE;
            else begin
              req_n = 1'b1; sel_n = tgt; maddr_n = addr;
            end
          end else if (scl_fall) begin
            phase_n = PH_TX; oe_n = ~txreg[7]; cnt_n = 4'd1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      phase <= PH_IDLE; kind <= K_DEV; cnt <= '0; shreg <= '0; txreg <= '0;
      sda_oe <= 1'b0; addr <= '0; addr_hi <= '0; tgt <= 1'b0; rd_mode <= 1'b0;
      dw_valid <= 1'b0; dw_tgt <= 1'b0; cap <= 1'b0;
      mem_req <= 1'b0; mem_we <= 1'b0; mem_sel <= 1'b0; mem_addr <= '0; mem_wdata <= '0;
    end else begin
      phase <= phase_n; kind <= kind_n; cnt <= cnt_n; shreg <= sh_n; txreg <= tx_n;
      sda_oe <= oe_n; addr <= addr_n; addr_hi <= hi_n; tgt <= tgt_n; rd_mode <= rd_n;
      dw_valid <= dw_n; dw_tgt <= dwt_n; cap <= cap_n;
      mem_req <= req_n; mem_we <= we_n; mem_sel <= sel_n; mem_addr <= maddr_n; mem_wdata <= wd_n;
    end
  end
endmodule

// File: rtl/twin_i2c_slave.sv
module twin_i2c_slave #(
  parameter int         ADDR_W   = 15,
  parameter int         PAGE_W   = 7,
  parameter int         REG_AW   = 8,
  parameter logic [6:0] ARRAY_ID = 7'b1010111,
  parameter logic [6:0] REGS_ID  = 7'b1101111
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_sel,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata
);
  logic rst_ns, scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;

  dts_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_ns(rst_ns));

  dts_line_sync u_line (
    .clk(clk), .rst_ns(rst_ns), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop)
  );

  dts_engine #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .REG_AW(REG_AW),
    .ARRAY_ID(ARRAY_ID), .REGS_ID(REGS_ID)
  ) u_eng (
    .clk(clk), .rst_ns(rst_ns), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop), .sda_oe(sda_oe),
    .mem_req(mem_req), .mem_we(mem_we), .mem_sel(mem_sel), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );
endmodule

// File: rtl/twin_i2c_slave_chk.sv
module twin_i2c_slave_chk #(
  parameter int ADDR_W = 15,
  parameter int PAGE_W = 7,
  parameter int REG_AW = 8
) (
  input logic              clk,
  input logic              rst_ns,
  input logic              scl_s,
  input logic              bus_start,
  input logic              bus_stop,
  input logic              sda_oe,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_sel,
  input logic [ADDR_W-1:0] mem_addr
);
  logic              wr_seen;
  logic [ADDR_W-1:0] wr_last;

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      wr_seen <= 1'b0;
      wr_last <= '0;
    end else if (bus_start) begin
      wr_seen <= 1'b0;
    end else if (mem_req && mem_we) begin
      wr_seen <= 1'b1;
      wr_last <= mem_addr;
    end
  end

  // R12
  pull_in_low_clk_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(sda_oe) |-> !scl_s);

  // R10
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    bus_stop |=> !sda_oe);

  // R4
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    mem_req |=> !mem_req);

  // R5
  page_wrap_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (mem_req && mem_we && wr_seen && !bus_start) |->
      (mem_addr[ADDR_W-1:PAGE_W] == wr_last[ADDR_W-1:PAGE_W]) &&
      (mem_addr[PAGE_W-1:0] == PAGE_W'(wr_last[PAGE_W-1:0] + PAGE_W'(1))));

  // R11
  reg_window_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (mem_req && mem_sel) |-> (mem_addr[ADDR_W-1:REG_AW] == '0));
endmodule

bind twin_i2c_slave twin_i2c_slave_chk #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .REG_AW(REG_AW)
) u_chk (
  .clk(clk), .rst_ns(rst_ns), .scl_s(scl_s), .bus_start(bus_start), .bus_stop(bus_stop),
  .sda_oe(sda_oe), .mem_req(mem_req), .mem_we(mem_we), .mem_sel(mem_sel), .mem_addr(mem_addr)
);

// File: tb/twin_i2c_slave_test.sv
module twin_i2c_slave_test;
  localparam int         AW   = 15;
  localparam int         Q    = 4;
  localparam logic [6:0] ID_A = 7'b1010111;
  localparam logic [6:0] ID_R = 7'b1101111;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, m_scl, m_sda;
  logic sda_oe, mem_req, mem_we, mem_sel;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  wire sda_bus = m_sda & ~sda_oe;

  twin_i2c_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .mem_req(mem_req), .mem_we(mem_we), .mem_sel(mem_sel), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  logic [7:0] arr_m [int];
  logic [7:0] reg_m [int];
  logic [7:0] exp_a [int];
  logic [7:0] exp_r [int];
  int n_chk = 0, n_fail = 0, n_wr = 0, sda_viol = 0;
  bit done = 1'b0;

  function automatic logic [7:0] dflt(input bit s, input int k);
    if (s) return k[7:0] ^ 8'hA5;
    return k[7:0] + 8'(k[14:8] * 3);
  endfunction

  function automatic logic [7:0] exp_rd(input bit s, input int k);
    if (s) return exp_r.exists(k) ? exp_r[k] : dflt(1'b1, k);
    return exp_a.exists(k) ? exp_a[k] : dflt(1'b0, k);
  endfunction

  // storage model behind the memory port
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        n_wr++;
        if (mem_sel) reg_m[int'(mem_addr)] = mem_wdata;
        else         arr_m[int'(mem_addr)] = mem_wdata;
      end else begin
        if (mem_sel) mem_rdata <= reg_m.exists(int'(mem_addr)) ? reg_m[int'(mem_addr)] : dflt(1'b1, int'(mem_addr));
        else         mem_rdata <= arr_m.exists(int'(mem_addr)) ? arr_m[int'(mem_addr)] : dflt(1'b0, int'(mem_addr));
      end
    end
  end

  // R12: the pull-down may only move while SCL is low
  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && sda_oe !== oe_prev && m_scl) sda_viol++;
    oe_prev <= sda_oe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start();
    m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q); m_sda = 1'b0; tick(Q); m_scl = 1'b0; tick(Q);
  endtask

  task automatic do_stop();
    m_sda = 1'b0; tick(Q); m_scl = 1'b1; tick(Q); m_sda = 1'b1; tick(2*Q);
  endtask

  task automatic put_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; tick(Q); m_scl = 1'b1; tick(2*Q); m_scl = 1'b0; tick(Q);
    end
    m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q); ack = sda_oe; tick(Q); m_scl = 1'b0; tick(Q);
  endtask

  task automatic get_byte(input bit nack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q); b[i] = sda_bus; tick(Q); m_scl = 1'b0; tick(Q);
    end
    m_sda = nack; tick(Q); m_scl = 1'b1; tick(2*Q); m_scl = 1'b0; tick(Q);
  endtask

  function automatic int wrap_rd(input bit s, input int a, input int i);
    return s ? ((a + i) & 255) : ((a + i) & 32767);
  endfunction

  function automatic int wrap_pg(input bit s, input int a, input int i);
    int base;
    base = s ? (a & 255) : (a & 32767);
    return (base & ~127) | ((base + i) & 127);
  endfunction

  // R3 R4 R5: page write with acknowledge and storage checks
  task automatic page_write(input bit s, input int a, input int n);
    bit ack; logic [7:0] d; int k;
    do_start();
    put_byte({s ? ID_R : ID_A, 1'b0}, ack); chk(ack, "R2 write slave byte ack", ack, 1);
    put_byte(8'(a >> 8), ack);              chk(ack, "R3 address high ack", ack, 1);
    put_byte(8'(a), ack);                   chk(ack, "R3 address low ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      put_byte(d, ack); chk(ack, "R4 data ack", ack, 1);
      k = wrap_pg(s, a, i);
      if (s) exp_r[k] = d; else exp_a[k] = d;
    end
    do_stop();
    for (int i = 0; i < n; i++) begin
      k = wrap_pg(s, a, i);
      if (s) chk(reg_m.exists(k) && reg_m[k] == exp_r[k], "R5 register page content", k, int'(exp_r[k]));
      else   chk(arr_m.exists(k) && arr_m[k] == exp_a[k], "R5 array page content", k, int'(exp_a[k]));
    end
  endtask

  // R9: dummy write, repeated start, sequential read
  task automatic rand_read(input bit s, input int a, input int n);
    bit ack; logic [7:0] b; int k;
    do_start();
    put_byte({s ? ID_R : ID_A, 1'b0}, ack); chk(ack, "R9 dummy slave ack", ack, 1);
    put_byte(8'(a >> 8), ack);              chk(ack, "R3 address high ack", ack, 1);
    put_byte(8'(a), ack);                   chk(ack, "R3 address low ack", ack, 1);
    do_start();
    put_byte({s ? ID_R : ID_A, 1'b1}, ack); chk(ack, "R9 read slave ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      get_byte(i == n - 1, b);
      k = wrap_rd(s, a, i);
      chk(b == exp_rd(s, k), "R9 read data", int'(b), int'(exp_rd(s, k)));
    end
    do_stop();
  endtask

  // R6 R7: read from the internal counter
  task automatic cur_read(input bit s, input int a, input int n, input string tag);
    bit ack; logic [7:0] b; int k;
    do_start();
    put_byte({s ? ID_R : ID_A, 1'b1}, ack); chk(ack, "R2 read slave byte ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      get_byte(i == n - 1, b);
      k = wrap_rd(s, a, i);
      chk(b == exp_rd(s, k), tag, int'(b), int'(exp_rd(s, k)));
    end
    do_stop();
  endtask

  initial begin
    bit ack; int w0, s, a, n;
    void'($urandom(32'd1286));
    rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1;
    tick(5); rst_n = 1'b1; tick(5);
    // R10 reset state
    chk(sda_oe == 1'b0, "R10 reset sda released", sda_oe, 0);
    chk(mem_req == 1'b0, "R10 reset no request", mem_req, 0);

    cur_read(1'b0, 0, 3, "R6 power-up read from 0");
    cur_read(1'b0, 3, 1, "R7 counter continues");
    cur_read(1'b1, 4, 2, "R7 shared counter into register space");

    // R1: foreign identifiers are not acknowledged
    w0 = n_wr;
    do_start(); put_byte({7'b1010110, 1'b0}, ack); chk(ack == 1'b0, "R1 foreign id nack", ack, 0); do_stop();
    do_start(); put_byte({7'b1101110, 1'b1}, ack); chk(ack == 1'b0, "R1 foreign id nack", ack, 0); do_stop();
    chk(n_wr == w0, "R1 no write from foreign id", n_wr - w0, 0);

    // R4 single byte write
    page_write(1'b0, 'h1234, 1);
    chk(n_wr == w0 + 1, "R4 one request per byte", n_wr - w0, 1);

    // R5 wrap across the page end
    page_write(1'b0, 'h2A7C, 10);
    chk(!arr_m.exists('h2A80), "R5 next page untouched", 1, 0);
    rand_read(1'b0, 'h2A00, 6);

    // R11 register space ignores the high address byte
    page_write(1'b1, 'h5521, 1);
    chk(reg_m.exists('h21), "R11 register low byte used", 0, 1);
    chk(!reg_m.exists('h5521) && !arr_m.exists('h5521), "R11 high byte ignored", 1, 0);
    rand_read(1'b1, 'h21, 1);
    rand_read(1'b1, 'hFE, 4);

    // R8 target mismatch between dummy write and read
    do_start();
    put_byte({ID_A, 1'b0}, ack); put_byte(8'h01, ack); put_byte(8'h02, ack);
    do_start(); put_byte({ID_R, 1'b1}, ack);
    chk(ack == 1'b0, "R8 array then register read nack", ack, 0);
    do_stop();
    do_start();
    put_byte({ID_R, 1'b0}, ack); put_byte(8'h00, ack); put_byte(8'h10, ack);
    do_start(); put_byte({ID_A, 1'b1}, ack);
    chk(ack == 1'b0, "R8 register then array read nack", ack, 0);
    do_stop();

    // R10 stop part way through a write
    w0 = n_wr;
    do_start(); put_byte({ID_A, 1'b0}, ack); put_byte(8'h01, ack); do_stop();
    chk(sda_oe == 1'b0, "R10 released after stop", sda_oe, 0);
    chk(n_wr == w0, "R10 no write after early stop", n_wr - w0, 0);
    rand_read(1'b0, 'h0100, 2);

    // random mix, R4 R5 R9
    for (int it = 0; it < 14; it++) begin
      s = int'($urandom % 2);
      a = int'($urandom & 32767);
      n = 1 + int'($urandom % 12);
      page_write(s[0], a, n);
      rand_read(s[0], wrap_pg(s[0], a, int'($urandom % 12)), 1 + int'($urandom % 5));
    end

    chk(sda_viol == 0, "R12 sda moved while scl high", sda_viol, 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule